// File: doc/BRIEF.md
# Dual-Channel Line Delay Memory

This block holds two separate storage channels. Each one is a circular array of nibble words with its own clock, and it is addressed only by a write pointer and a read pointer. Neither pointer looks at the other. No full or empty logic exists. A pointer moves only when its active-low step strobe is asserted, and it returns to address zero when its active-low clear strobe is asserted. When a pointer passes the last address it wraps back to zero.

The typical use is a video line or field delay. If both pointers of a channel are cleared on the same edge and then stepped on every cycle, each word comes out exactly `DEPTH` cycles after it went in. This works because the read of an address takes the stored word before that edge's write to the same address lands. Other delay lengths come from clearing the pointers at offset times, or from holding the read pointer for a number of cycles.

The tri-state output of each channel is modelled as a registered data word plus a registered output-enable flag. Each channel has its own asynchronous active-low reset, which is released in step with that channel's clock.

Top module: `dual_line_memory`

## Requirements
- R1: While a channel's reset input is low, its output-enable is 0 and its output data is 0. After reset, both pointers start at address 0, so the first word written is the first word read.
- R2: On an edge with write step low and write clear high, the input word is stored at the write pointer and the pointer advances. With write step high, nothing is stored and the pointer holds.
- R3: On an edge with read step low and read clear high, the word at the read pointer appears on the output after that edge, output-enable is 1, and the read pointer advances.
- R4: On an edge with read step high and read clear high, output-enable is 0 after that edge and the read pointer holds.
- R5: On an edge with write clear low, the write pointer becomes 0 and nothing is stored, whatever the write step and input word are. The next stored word goes to address 0.
- R6: On an edge with read clear low, the read pointer becomes 0, no word is read, and output-enable is 0 after that edge, whatever the read step is.
- R7: Both pointers wrap from address DEPTH-1 to address 0 when they step.
- R8: A read and a write of the same address on the same edge return the previously stored word. Clearing both pointers together and then stepping both every cycle therefore delays each word by exactly DEPTH cycles.
- R9: The two channels share no state. Traffic on one channel never changes the stored words, pointers or outputs of the other.
- R10: On any edge without a read step, the output data word keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Channel A clock |
| a_rst_n | input | 1 | Channel A asynchronous reset, active low |
| a_wr_n | input | 1 | Channel A write step, active low |
| a_wclr_n | input | 1 | Channel A write pointer clear, active low |
| a_wdata | input | DW | Channel A input word |
| a_rd_n | input | 1 | Channel A read step, active low |
| a_rclr_n | input | 1 | Channel A read pointer clear, active low |
| a_rdata | output | DW | Channel A output word |
| a_oe | output | 1 | Channel A output-enable (1 = bus driven) |
| b_clk | input | 1 | Channel B clock |
| b_rst_n | input | 1 | Channel B asynchronous reset, active low |
| b_wr_n | input | 1 | Channel B write step, active low |
| b_wclr_n | input | 1 | Channel B write pointer clear, active low |
| b_wdata | input | DW | Channel B input word |
| b_rd_n | input | 1 | Channel B read step, active low |
| b_rclr_n | input | 1 | Channel B read pointer clear, active low |
| b_rdata | output | DW | Channel B output word |
| b_oe | output | 1 | Channel B output-enable (1 = bus driven) |

## Verification
The cycle-by-cycle assertions cover the output side of each channel: output-enable following read step and read clear one edge later, the output word holding on edges without a read, and the quiet outputs during reset. What the assertions cannot see is the address each word goes to. Stored words, pointer holds and clears, wrap-around, the exact DEPTH-cycle delay and the isolation between channels only show up in the bench's scenarios, where a reference model predicts every output word.

// File: rtl/lm_pkg.sv
package lm_pkg;

  // Per-side command decoded from the active-low strobes; clear wins over step.
  typedef enum logic [1:0] {
    SIDE_IDLE  = 2'd0,
    SIDE_STEP  = 2'd1,
    SIDE_CLEAR = 2'd2
  } side_cmd_t;

  function automatic side_cmd_t side_decode(input logic clr_n, input logic step_n);
    side_cmd_t cmd;
    if (!clr_n) begin
      cmd = SIDE_CLEAR;
    end else if (!step_n) begin
      cmd = SIDE_STEP;
    end else begin
      cmd = SIDE_IDLE;
    end
    return cmd;
  endfunction

endpackage

// File: rtl/lm_rst_sync.sv
module lm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/lm_addr_ctr.sv
module lm_addr_ctr
  import lm_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  side_cmd_t     cmd,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    unique case (cmd)
      SIDE_CLEAR: addr_d = '0;
      SIDE_STEP:  addr_d = (addr_q == LAST) ? '0 : addr_q + 1'b1;
      default:    addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/lm_store.sv
module lm_store
  import lm_pkg::*;
#(
  parameter  int DEPTH = 1024,
  parameter  int DW    = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  side_cmd_t     wr_cmd,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  side_cmd_t     rd_cmd,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          oe
);

  logic [DW-1:0] mem_q [DEPTH];

  logic          wr_en;
  logic          rd_en;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;
  logic          oe_q;
  logic          oe_d;

  assign wr_en = (wr_cmd == SIDE_STEP);
  assign rd_en = (rd_cmd == SIDE_STEP);

  // Array has no reset; the write lands at the closing edge of the cycle.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[waddr] <= wdata;
    end
  end

  // Read samples the array content from before this edge's write.
  always_comb begin
    rdata_d = rdata_q;
    oe_d    = 1'b0;
    if (rd_en) begin
      rdata_d = mem_q[raddr];
      oe_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      oe_q    <= oe_d;
    end
  end

  assign rdata = rdata_q;
  assign oe    = oe_q;

endmodule

// File: rtl/lm_channel.sv
module lm_channel
  import lm_pkg::*;
#(
  parameter  int DEPTH = 1024,
  parameter  int DW    = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_n,
  input  logic          wclr_n,
  input  logic [DW-1:0] wdata,
  input  logic          rd_n,
  input  logic          rclr_n,
  output logic [DW-1:0] rdata,
  output logic          oe
);

  logic          rst_n;
  side_cmd_t     wr_cmd;
  side_cmd_t     rd_cmd;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;

  lm_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign wr_cmd = side_decode(wclr_n, wr_n);
  assign rd_cmd = side_decode(rclr_n, rd_n);

  lm_addr_ctr #(.DEPTH(DEPTH)) u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (wr_cmd),
    .addr  (waddr)
  );

  lm_addr_ctr #(.DEPTH(DEPTH)) u_rptr (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (rd_cmd),
    .addr  (raddr)
  );

  lm_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_cmd (wr_cmd),
    .waddr  (waddr),
    .wdata  (wdata),
    .rd_cmd (rd_cmd),
    .raddr  (raddr),
    .rdata  (rdata),
    .oe     (oe)
  );

endmodule

// File: rtl/dual_line_memory.sv
module dual_line_memory #(
  parameter int DEPTH = 1024,
  parameter int DW    = 4
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_wr_n,
  input  logic          a_wclr_n,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_rd_n,
  input  logic          a_rclr_n,
  output logic [DW-1:0] a_rdata,
  output logic          a_oe,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_wr_n,
  input  logic          b_wclr_n,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_rd_n,
  input  logic          b_rclr_n,
  output logic [DW-1:0] b_rdata,
  output logic          b_oe
);

  localparam int NCH = 2;

  logic          clk_v    [NCH];
  logic          rst_n_v  [NCH];
  logic          wr_n_v   [NCH];
  logic          wclr_n_v [NCH];
  logic [DW-1:0] wdata_v  [NCH];
  logic          rd_n_v   [NCH];
  logic          rclr_n_v [NCH];
  logic [DW-1:0] rdata_v  [NCH];
  logic          oe_v     [NCH];

  assign clk_v[0]    = a_clk;
  assign rst_n_v[0]  = a_rst_n;
  assign wr_n_v[0]   = a_wr_n;
  assign wclr_n_v[0] = a_wclr_n;
  assign wdata_v[0]  = a_wdata;
  assign rd_n_v[0]   = a_rd_n;
  assign rclr_n_v[0] = a_rclr_n;

  assign clk_v[1]    = b_clk;
  assign rst_n_v[1]  = b_rst_n;
  assign wr_n_v[1]   = b_wr_n;
  assign wclr_n_v[1] = b_wclr_n;
  assign wdata_v[1]  = b_wdata;
  assign rd_n_v[1]   = b_rd_n;
  assign rclr_n_v[1] = b_rclr_n;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      lm_channel #(.DEPTH(DEPTH), .DW(DW)) u_chan (
        .clk    (clk_v[c]),
        .arst_n (rst_n_v[c]),
        .wr_n   (wr_n_v[c]),
        .wclr_n (wclr_n_v[c]),
        .wdata  (wdata_v[c]),
        .rd_n   (rd_n_v[c]),
        .rclr_n (rclr_n_v[c]),
        .rdata  (rdata_v[c]),
        .oe     (oe_v[c])
      );
    end
  endgenerate

  assign a_rdata = rdata_v[0];
  assign a_oe    = oe_v[0];
  assign b_rdata = rdata_v[1];
  assign b_oe    = oe_v[1];

endmodule

// File: rtl/lm_read_chk.sv
module lm_read_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          rclr_n,
  input logic [DW-1:0] rdata,
  input logic          oe
);

  // Edges counted since reset release; the channel runs normally once two
  // edges have passed through its reset synchronizer.
  logic [1:0] settle_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= 2'd0;
    end else if (settle_q != 2'd3) begin
      settle_q <= settle_q + 2'd1;
    end
  end

  assign live = (settle_q >= 2'd2);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!oe && (rdata == '0)));

  // R3
  read_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rd_n && rclr_n) |=> oe);

  // R4
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rd_n && rclr_n) |=> !oe);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rclr_n) |=> !oe);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (rd_n || !rclr_n)) |=> $stable(rdata));

endmodule

bind dual_line_memory lm_read_chk #(.DW(DW)) chk_a_i (
  .clk    (a_clk),
  .rst_n  (a_rst_n),
  .rd_n   (a_rd_n),
  .rclr_n (a_rclr_n),
  .rdata  (a_rdata),
  .oe     (a_oe)
);

bind dual_line_memory lm_read_chk #(.DW(DW)) chk_b_i (
  .clk    (b_clk),
  .rst_n  (b_rst_n),
  .rd_n   (b_rd_n),
  .rclr_n (b_rclr_n),
  .rdata  (b_rdata),
  .oe     (b_oe)
);

// File: tb/dual_line_memory_tb_top.sv
module dual_line_memory_tb_top;

  localparam int DEPTH = 16;
  localparam int DW    = 4;

  logic          a_clk, a_rst_n, a_wr_n, a_wclr_n, a_rd_n, a_rclr_n, a_oe;
  logic [DW-1:0] a_wdata, a_rdata;
  logic          b_clk, b_rst_n, b_wr_n, b_wclr_n, b_rd_n, b_rclr_n, b_oe;
  logic [DW-1:0] b_wdata, b_rdata;

  initial a_clk = 1'b0;
  always #2 a_clk = ~a_clk;

  initial begin
    b_clk = 1'b0;
    #1;
    forever #2 b_clk = ~b_clk;
  end

  dual_line_memory #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_wr_n(a_wr_n), .a_wclr_n(a_wclr_n),
    .a_wdata(a_wdata), .a_rd_n(a_rd_n), .a_rclr_n(a_rclr_n),
    .a_rdata(a_rdata), .a_oe(a_oe),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_wr_n(b_wr_n), .b_wclr_n(b_wclr_n),
    .b_wdata(b_wdata), .b_rd_n(b_rd_n), .b_rclr_n(b_rclr_n),
    .b_rdata(b_rdata), .b_oe(b_oe)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       oe;
    logic       known;
    logic [3:0] d;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];

  // Reference model built from the requirements
  logic [3:0] m_mem   [2][DEPTH];
  logic       m_known [2][DEPTH];
  int         m_wa [2];
  int         m_ra [2];
  logic [3:0] m_out [2];
  logic       m_outk [2];

  int n_chk;
  int n_fail;
  bit done;

  task automatic compare(input int ch, input exp_t e, input logic oe, input logic [3:0] d);
    bit ok;
    ok = (oe === e.oe) && (!e.known || (d === e.d));
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d ch%0d: oe=%b data=%h expected oe=%b data=%h",
               e.req, ch, oe, d, e.oe, e.d);
    end
  endtask

  task automatic drive(input int ch, input logic wr_n, input logic wclr_n,
                       input logic [3:0] wd, input logic rd_n, input logic rclr_n,
                       input int req);
    exp_t e;
    if (ch == 0) begin
      @(negedge a_clk);
      a_wr_n = wr_n; a_wclr_n = wclr_n; a_wdata = wd; a_rd_n = rd_n; a_rclr_n = rclr_n;
    end else begin
      @(negedge b_clk);
      b_wr_n = wr_n; b_wclr_n = wclr_n; b_wdata = wd; b_rd_n = rd_n; b_rclr_n = rclr_n;
    end
    // read side first: it sees the stored words from before this edge (R8)
    if (!rclr_n) begin
      m_ra[ch] = 0;
      e.oe = 1'b0;
    end else if (!rd_n) begin
      m_out[ch]  = m_mem[ch][m_ra[ch]];
      m_outk[ch] = m_known[ch][m_ra[ch]];
      m_ra[ch]   = (m_ra[ch] == DEPTH - 1) ? 0 : m_ra[ch] + 1;
      e.oe = 1'b1;
    end else begin
      e.oe = 1'b0;
    end
    if (!wclr_n) begin
      m_wa[ch] = 0;
    end else if (!wr_n) begin
      m_mem[ch][m_wa[ch]]   = wd;
      m_known[ch][m_wa[ch]] = 1'b1;
      m_wa[ch] = (m_wa[ch] == DEPTH - 1) ? 0 : m_wa[ch] + 1;
    end
    e.req   = 8'(req);
    e.known = m_outk[ch];
    e.d     = m_out[ch];
    if (ch == 0) qa.push_back(e);
    else         qb.push_back(e);
  endtask

  // Monitors: one expected item per edge of each channel
  initial begin
    exp_t e;
    forever begin
      @(posedge a_clk);
      #1;
      if (qa.size() > 0) begin
        e = qa.pop_front();
        compare(0, e, a_oe, a_rdata);
      end
    end
  end

  initial begin
    exp_t e;
    forever begin
      @(posedge b_clk);
      #1;
      if (qb.size() > 0) begin
        e = qb.pop_front();
        compare(1, e, b_oe, b_rdata);
      end
    end
  end

  task automatic run_chan(input int ch, input int s);
    // R1 R2 R3: first writes land at address 0 onward and read back in order
    for (int i = 0; i < 4; i++) drive(ch, 0, 1, 4'(i + s), 1, 1, 2);
    for (int i = 0; i < 4; i++) drive(ch, 1, 1, 4'h0, 0, 1, 3);
    // R2: cycles with write step high store nothing and hold the pointer
    drive(ch, 0, 1, 4'(8 + s), 1, 1, 2);
    drive(ch, 0, 1, 4'(9 + s), 1, 1, 2);
    drive(ch, 1, 1, 4'hF, 1, 1, 2);
    drive(ch, 1, 1, 4'hE, 1, 1, 2);
    drive(ch, 0, 1, 4'(10 + s), 1, 1, 2);
    drive(ch, 0, 1, 4'(11 + s), 1, 1, 2);
    drive(ch, 1, 1, 4'h0, 1, 0, 6);
    for (int i = 0; i < 8; i++) drive(ch, 1, 1, 4'h0, 0, 1, 2);
    // R4: idle read cycles hold the read pointer and drop output-enable
    drive(ch, 1, 1, 4'h0, 1, 0, 6);
    for (int i = 0; i < 3; i++) drive(ch, 1, 1, 4'h0, 1, 1, 4);
    for (int i = 0; i < 2; i++) drive(ch, 1, 1, 4'h0, 0, 1, 4);
    // R5: write clear wins over a write step, stores nothing
    drive(ch, 0, 0, 4'(s ^ 10), 1, 1, 5);
    drive(ch, 0, 1, 4'(s ^ 3), 1, 1, 5);
    drive(ch, 1, 1, 4'h0, 1, 0, 5);
    drive(ch, 1, 1, 4'h0, 0, 1, 5);
    drive(ch, 1, 1, 4'h0, 0, 1, 5);
    // R6: read clear wins over a read step
    drive(ch, 1, 1, 4'h0, 0, 0, 6);
    drive(ch, 1, 1, 4'h0, 0, 1, 6);
    // R10: output word holds across idle and clear cycles
    drive(ch, 1, 1, 4'h0, 1, 1, 10);
    drive(ch, 1, 1, 4'h0, 0, 0, 10);
    drive(ch, 1, 1, 4'h0, 1, 1, 10);
    // R8: joint clear then continuous traffic gives a DEPTH-cycle delay;
    // R7: the second and third lines pass both pointers through the wrap
    drive(ch, 1, 0, 4'h0, 1, 0, 8);
    for (int k = 0; k < 2 * DEPTH + 4; k++)
      drive(ch, 0, 1, 4'(k * 3 + s), 0, 1, (k < DEPTH) ? 8 : 7);
    // R9: channel A reads its line back while channel B rewrites its own
    if (ch == 0) begin
      drive(ch, 1, 1, 4'h0, 1, 0, 9);
      for (int k = 0; k < DEPTH; k++) drive(ch, 1, 1, 4'h0, 0, 1, 9);
    end else begin
      drive(ch, 1, 0, 4'h0, 1, 1, 9);
      for (int k = 0; k < DEPTH; k++) drive(ch, 0, 1, 4'(k ^ 6), 1, 1, 9);
    end
    drive(ch, 1, 1, 4'h0, 1, 1, 4);
  endtask

  initial begin
    exp_t r;
    done = 1'b0;
    n_chk = 0;
    n_fail = 0;
    for (int c = 0; c < 2; c++) begin
      m_wa[c] = 0;
      m_ra[c] = 0;
      m_out[c] = 4'h0;
      m_outk[c] = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        m_mem[c][i] = 4'h0;
        m_known[c][i] = 1'b0;
      end
    end
    a_wr_n = 1; a_wclr_n = 1; a_wdata = 0; a_rd_n = 1; a_rclr_n = 1;
    b_wr_n = 1; b_wclr_n = 1; b_wdata = 0; b_rd_n = 1; b_rclr_n = 1;
    a_rst_n = 1; b_rst_n = 1;
    #1;
    a_rst_n = 0; b_rst_n = 0;
    #9;
    // R1: outputs quiet while in reset
    r.req = 8'd1; r.oe = 1'b0; r.known = 1'b1; r.d = 4'h0;
    compare(0, r, a_oe, a_rdata);
    compare(1, r, b_oe, b_rdata);
    #11;
    a_rst_n = 1; b_rst_n = 1;
    repeat (5) @(negedge a_clk);
    compare(0, r, a_oe, a_rdata);
    compare(1, r, b_oe, b_rdata);
    fork
      run_chan(0, 0);
      run_chan(1, 5);
    join
    repeat (4) @(negedge a_clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R0 watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule